// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block is the transmit half of a serial port. One control byte, written through a simple write strobe, chooses the operating mode. In asynchronous mode it sends framed characters on a data pin that idles high. In synchronous mode it shifts bare data bits against a clock. The clock is either generated here (master) or taken from an external pin (slave). A separate write select loads a data holding byte. The holding byte is double-buffered in front of the shift register, so software can queue the next character while the current one is still leaving.

The bit rate comes from a divisor input. The bit period is (divisor+1) system clocks times a multiplier. The multiplier is 16 or 64 in asynchronous mode, chosen by a speed bit, and 4 in synchronous master mode. An optional ninth data bit, taken from the control byte, can serve as an address marker or a parity bit. In synchronous mode either receive enable input takes priority over the transmit enable: the data and clock pins are released and any character in flight is dropped. The status output mirrors the control byte and adds a shift-register-empty flag.

Top module: `usart_tx`

## Requirements
- R1: After reset, status_o reads 8'h02 (only the empty flag set), txd_o is high and sck_oe is low.
- R2: A write with wr_sel=0 stores control bits 7 (clock master), 6 (nine-bit), 5 (enable), 4 (synchronous), 2 (fast rate) and 0 (ninth bit). These read back at the same positions of status_o from the next cycle. Bit 3 always reads 0, and bit 1 reads 1 exactly when the shift register is empty.
- R3: In asynchronous mode a character is sent as one low start bit, then the data bits LSB first, then one high stop bit. Each bit lasts (baud_div+1)*16 clocks when bit 2 is 1 and (baud_div+1)*64 clocks when bit 2 is 0.
- R4: With bit 6 set, control bit 0 (as it stood at load) is sent as a ninth data bit directly after data bit 7, in both modes.
- R5: A write with wr_sel=1 fills the holding register. On the first clock edge at which the transmitter is enabled, not overridden and empty, the holding register moves into the shift register and status bit 1 drops. A character queued during a frame starts one clock after the previous frame ends.
- R6: While bit 5 is 0, nothing is sent and queued data waits. Clearing bit 5 during a frame aborts it, and the line returns to idle on the next clock.
- R7: In synchronous master mode (bits 4 and 7 set) the data bits go out LSB first with no start or stop bit. Each bit lasts (baud_div+1)*4 clocks. sck_oe is high only while shifting. sck_o is low for the first half of each bit and high for the second half, so data changes on the falling edge. Bit 2 has no effect.
- R8: In synchronous slave mode (bit 4 set, bit 7 clear) sck_oe stays low. The first bit is presented at load, and the data advances on the third system clock edge after each falling edge of sck_i.
- R9: In synchronous mode, a high rx_single_en or rx_cont_en drops txd_oe and sck_oe, aborts any frame and holds queued data. In asynchronous mode these inputs have no effect.
- R10: In asynchronous mode txd_oe is always high, txd_o is high whenever the shift register is empty, and control bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control byte, 1 data holding register |
| wr_data | input | DATA_W | Write data; control uses the low 8 bits |
| baud_div | input | DIV_W | Bit-rate divisor |
| rx_single_en | input | 1 | Single-receive enable (synchronous override) |
| rx_cont_en | input | 1 | Continuous-receive enable (synchronous override) |
| status_o | output | 8 | Control readback with empty flag at bit 1 |
| txd_o | output | 1 | Serial data out |
| txd_oe | output | 1 | Data pin drive enable |
| sck_i | input | 1 | External clock in (slave mode) |
| sck_o | output | 1 | Generated clock out (master mode) |
| sck_oe | output | 1 | Clock pin drive enable |

## Verification
The bench targets the edges between frames. A character queued mid-frame must start exactly one clock after the stop bit; a design that loaded late or early would shift every later bit. It switches the rate bit in synchronous mode, where a design that wrongly honoured it would stretch the clock fourfold. It asserts a receive enable in mid-frame; a design that ignored the override would keep driving both pins, and one that did not drop the frame would resume with stale bits. The ninth bit, the slave clock latency and an enable cleared during a frame are also exercised. Each of these would show up as a bit-timing or drive-enable mismatch against the bench model.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
  localparam int CTL_W     = 8;
  localparam int CTL_MASTER = 7;
  localparam int CTL_NINE   = 6;
  localparam int CTL_EN     = 5;
  localparam int CTL_SYNC   = 4;
  localparam int CTL_FAST   = 2;
  localparam int CTL_EMPTY  = 1;
  localparam int CTL_BIT9   = 0;
  localparam logic [CTL_W-1:0] CTL_WMASK = 8'hF5;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  typedef enum logic [1:0] {
    RATE_SYNC = 2'd0,
    RATE_FAST = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;
endpackage

// File: rtl/usart_rst_sync.sv
module usart_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/usart_baud_gen.sv
module usart_baud_gen
  import usart_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  rate_e            rate,
  output logic             tick,
  output logic             high_half
);
  localparam int PER_W = DIV_W + 7;
  localparam int CNT_W = DIV_W + 6;

  logic [PER_W-1:0] base;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    base = PER_W'(div) + PER_W'(1);
    unique case (rate)
      RATE_SYNC: period = base << 2;
      RATE_FAST: period = base << 4;
      default:   period = base << 6;
    endcase
    limit     = period - PER_W'(1);
    tick      = run && (cnt_q == limit[CNT_W-1:0]);
    high_half = PER_W'(cnt_q) >= (period >> 1);
  end

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usart_edge_sync.sv
module usart_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall
);
  localparam int HW = SYNC_STAGES + 1;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_d;

  always_comb begin
    hist_d = {hist_q[HW-2:0], pin_i};
    fall   = hist_q[HW-1] & ~hist_q[HW-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/usart_tx_shifter.sv
module usart_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              pending,
  input  logic [DATA_W-1:0] data,
  input  logic              ninth_en,
  input  logic              ninth_bit,
  input  logic              sync_mode,
  input  logic              adv,
  output logic              load,
  output logic              busy,
  output logic              bit_o
);
  localparam int SR_W   = DATA_W + 3;
  localparam int LEFT_W = $clog2(SR_W + 1);

  logic [SR_W-1:0]   sr_q, sr_d, frame;
  logic [LEFT_W-1:0] left_q, left_d, nbits;
  logic              busy_q, busy_d;

  always_comb begin
    frame = '1;
    if (sync_mode) begin
      frame[DATA_W-1:0] = data;
      frame[DATA_W]     = ninth_en ? ninth_bit : 1'b1;
    end else begin
      frame[0]          = 1'b0;
      frame[DATA_W:1]   = data;
      frame[DATA_W+1]   = ninth_en ? ninth_bit : 1'b1;
    end
    nbits = LEFT_W'(DATA_W) + LEFT_W'(ninth_en) + (sync_mode ? LEFT_W'(0) : LEFT_W'(2));
  end

  always_comb begin
    load   = active && !busy_q && pending;
    sr_d   = sr_q;
    left_d = left_q;
    busy_d = busy_q;
    if (!active) begin
      sr_d   = '1;
      left_d = '0;
      busy_d = 1'b0;
    end else if (load) begin
      sr_d   = frame;
      left_d = nbits;
      busy_d = 1'b1;
    end else if (busy_q && adv) begin
      sr_d   = {1'b1, sr_q[SR_W-1:1]};
      left_d = left_q - LEFT_W'(1);
      busy_d = (left_q != LEFT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign busy  = busy_q;
  assign bit_o = busy_q ? sr_q[0] : 1'b1;
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rx_single_en,
  input  logic              rx_cont_en,
  output logic [CTL_W-1:0]  status_o,
  output logic              txd_o,
  output logic              txd_oe,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe
);
  logic              rst_s;
  logic [CTL_W-1:0]  ctrl_q, ctrl_d;
  logic              ctrl_we;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_full_q, hold_full_d;
  logic              hold_we;
  logic              sync_m, master_m, slave_m, active;
  rate_e             rate;
  logic              load, busy, bit_out, tick, high_half, fall, adv, run;

  usart_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s)
  );

  always_comb begin
    sync_m   = ctrl_q[CTL_SYNC];
    master_m = ctrl_q[CTL_MASTER];
    slave_m  = sync_m && !master_m;
    active   = ctrl_q[CTL_EN] && !(sync_m && (rx_single_en || rx_cont_en));
    if (sync_m)                 rate = RATE_SYNC;
    else if (ctrl_q[CTL_FAST])  rate = RATE_FAST;
    else                        rate = RATE_SLOW;
    run = busy && active && !slave_m;
    adv = slave_m ? fall : tick;
  end

  always_comb begin
    ctrl_we     = wr_en && (wr_sel == SEL_CTRL);
    ctrl_d      = wr_data[CTL_W-1:0] & CTL_WMASK;
    hold_we     = wr_en && (wr_sel == SEL_DATA);
    hold_d      = wr_data;
    hold_full_d = hold_full_q;
    if (load)    hold_full_d = 1'b0;
    if (hold_we) hold_full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q      <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (hold_we) hold_q <= hold_d;
      hold_full_q <= hold_full_d;
    end
  end

  usart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_s), .run(run), .div(baud_div), .rate(rate),
    .tick(tick), .high_half(high_half)
  );

  usart_edge_sync #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_s), .pin_i(sck_i), .fall(fall)
  );

  usart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_s), .active(active), .pending(hold_full_q),
    .data(hold_q), .ninth_en(ctrl_q[CTL_NINE]), .ninth_bit(ctrl_q[CTL_BIT9]),
    .sync_mode(sync_m), .adv(adv), .load(load), .busy(busy), .bit_o(bit_out)
  );

  always_comb begin
    status_o            = ctrl_q;
    status_o[CTL_EMPTY] = ~busy;
    txd_o               = bit_out;
    txd_oe              = sync_m ? (busy && active) : 1'b1;
    sck_oe              = sync_m && master_m && busy && active;
    sck_o               = (sync_m && master_m && busy) ? high_half : 1'b1;
  end
endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_low,
  input logic       rx_single_en,
  input logic       rx_cont_en,
  input logic [7:0] status_o,
  input logic       txd_o,
  input logic       txd_oe,
  input logic       sck_oe
);
  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && !wr_sel) |=> (status_o[7:4] == $past(wr_low[7:4])) &&
                           (status_o[2] == $past(wr_low[2])) &&
                           (status_o[0] == $past(wr_low[0])));

  assert_disabled_empties_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !status_o[5] |=> status_o[1]);

  assert_clock_only_shifting_R7: assert property (@(posedge clk) disable iff (!rst_s)
    sck_oe |-> !status_o[1]);

  assert_slave_no_clock_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (status_o[4] && !status_o[7]) |-> !sck_oe);

  assert_override_release_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (status_o[4] && (rx_single_en || rx_cont_en)) |-> (!txd_oe && !sck_oe));

  assert_async_drive_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !status_o[4] |-> txd_oe);

  assert_async_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (!status_o[4] && status_o[1]) |-> txd_o);
endmodule

bind usart_tx usart_tx_chk u_chk (
  .clk(clk), .rst_s(rst_s), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_low(wr_data[7:0]), .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
  .status_o(status_o), .txd_o(txd_o), .txd_oe(txd_oe), .sck_oe(sck_oe)
);

// File: tb/usart_tx_tb.sv
`timescale 1ns/1ps
module usart_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] baud_div = 8'h00;
  logic       rx_single_en = 1'b0;
  logic       rx_cont_en = 1'b0;
  logic       sck_i = 1'b1;
  logic [7:0] status_o;
  logic       txd_o, txd_oe, sck_o, sck_oe;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  usart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .baud_div(baud_div), .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
    .status_o(status_o), .txd_o(txd_o), .txd_oe(txd_oe),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe)
  );

  // behavioural reference model
  int   m_ctrl, m_hold, m_cnt, m_next, m_per;
  bit   m_full, m_busy, m_act, m_sync, m_master, m_fall;
  bit   m_q[$];
  bit   h1, h2, h3;

  function automatic int bit_period(int ctrl, int div);
    if (ctrl[4])      return (div + 1) * 4;
    else if (ctrl[2]) return (div + 1) * 16;
    else              return (div + 1) * 64;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_hold = 0; m_cnt = 0; m_full = 0; m_busy = 0;
      m_q.delete(); h1 = 1; h2 = 1; h3 = 1;
    end else begin
      m_sync   = m_ctrl[4];
      m_master = m_ctrl[7];
      m_act    = m_ctrl[5] && !(m_sync && (rx_single_en || rx_cont_en));
      m_fall   = h3 && !h2;
      m_per    = bit_period(m_ctrl, baud_div);
      m_next   = m_ctrl;
      if (wr_en && !wr_sel) m_next = wr_data & 8'hF5;
      if (!m_act) begin
        m_busy = 0; m_cnt = 0; m_q.delete();
      end else if (!m_busy) begin
        if (m_full) begin
          if (!m_sync) m_q.push_back(1'b0);
          for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
          if (m_ctrl[6]) m_q.push_back(m_ctrl[0]);
          if (!m_sync) m_q.push_back(1'b1);
          m_busy = 1; m_cnt = 0; m_full = 0;
        end
      end else if (m_sync && !m_master) begin
        if (m_fall) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
        end
      end else if (m_cnt == m_per - 1) begin
        m_cnt = 0;
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_busy = 0;
      end else begin
        m_cnt++;
      end
      if (wr_en && wr_sel) begin m_hold = wr_data; m_full = 1; end
      m_ctrl = m_next;
      h3 = h2; h2 = h1; h1 = sck_i;
    end
  end

  task automatic check_val(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (checking && !finished) begin
      bit s, ms, an, e_txd, e_oe, e_sck, e_sckoe;
      int p;
      s  = m_ctrl[4];
      ms = m_ctrl[7];
      an = m_ctrl[5] && !(s && (rx_single_en || rx_cont_en));
      p  = bit_period(m_ctrl, baud_div);
      e_txd   = m_busy ? m_q[0] : 1'b1;
      e_oe    = s ? (m_busy && an) : 1'b1;
      e_sckoe = s && ms && m_busy && an;
      e_sck   = (s && ms && m_busy) ? (m_cnt >= p / 2) : 1'b1;
      check_val(phase, "status_o", status_o, m_ctrl | (m_busy ? 0 : 2));
      check_val(phase, "txd_o", txd_o, e_txd);
      check_val(phase, "txd_oe", txd_oe, e_oe);
      check_val(phase, "sck_oe", sck_oe, e_sckoe);
      check_val(phase, "sck_o", sck_o, e_sck);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_reg(bit sel, logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 20000; i++) begin
      if (!m_busy && !m_full) break;
      @(negedge clk);
    end
    tick(2);
  endtask

  task automatic slave_clocks(int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 1'b0; tick(6);
      sck_i = 1'b1; tick(6);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    phase = "R1";
    check_val("R1", "reset status_o", status_o, 8'h02);
    check_val("R1", "reset txd_o", txd_o, 1);
    check_val("R1", "reset sck_oe", sck_oe, 0);
    checking = 1'b1;

    phase = "R2";
    write_reg(0, 8'hFF);
    tick(1);
    check_val("R2", "readback all ones", status_o, 8'hF7);
    write_reg(0, 8'h0A);
    tick(1);
    check_val("R2", "readback bit3 dropped", status_o, 8'h02);

    phase = "R3";
    baud_div = 8'd1;
    write_reg(0, 8'h24);
    write_reg(1, 8'hA5);
    wait_drain();

    phase = "R5";
    write_reg(1, 8'h3C);
    tick(5);
    write_reg(1, 8'hC3);
    tick(1);
    check_val("R5", "second byte queued, shifter busy", status_o[1], 0);
    wait_drain();

    phase = "R4";
    baud_div = 8'd0;
    write_reg(0, 8'h61);
    write_reg(1, 8'h5A);
    wait_drain();
    write_reg(0, 8'h60);
    write_reg(1, 8'h5A);
    wait_drain();

    phase = "R6";
    write_reg(0, 8'h04);
    write_reg(1, 8'h81);
    tick(50);
    check_val("R6", "disabled stays empty", status_o[1], 1);
    check_val("R6", "disabled line idle", txd_o, 1);
    write_reg(0, 8'h24);
    tick(40);
    write_reg(0, 8'h04);
    tick(1);
    check_val("R6", "abort returns idle", txd_o, 1);
    tick(10);

    phase = "R10";
    write_reg(0, 8'hA4);
    write_reg(1, 8'h69);
    wait_drain();

    phase = "R9";
    rx_cont_en = 1'b1;
    write_reg(1, 8'h0F);
    wait_drain();
    rx_cont_en = 1'b0;

    phase = "R7";
    baud_div = 8'd2;
    write_reg(0, 8'hB0);
    write_reg(1, 8'h3C);
    wait_drain();
    write_reg(0, 8'hB4);
    write_reg(1, 8'h3C);
    wait_drain();
    write_reg(0, 8'hF1);
    write_reg(1, 8'hE7);
    wait_drain();

    phase = "R9";
    write_reg(0, 8'hB0);
    write_reg(1, 8'hF0);
    tick(30);
    rx_cont_en = 1'b1;
    tick(1);
    check_val("R9", "override drops data drive", txd_oe, 0);
    tick(10);
    rx_cont_en = 1'b0;
    rx_single_en = 1'b1;
    write_reg(1, 8'h55);
    tick(20);
    check_val("R9", "override holds queued data", status_o[1], 1);
    rx_single_en = 1'b0;
    wait_drain();

    phase = "R8";
    write_reg(0, 8'h30);
    write_reg(1, 8'h96);
    tick(4);
    slave_clocks(9);
    wait_drain();
    check_val("R8", "slave frame complete", status_o[1], 1);

    tick(5);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule